// File: doc/BRIEF.md
# LCD frame fetch sequencer

This block runs the fetch of one display frame from a framebuffer held in memory. A frame tick starts it. It optionally reads the palette block at the start of the current frame buffer, and learns the pixel depth from the first palette entry. It then places pixel data behind a header and checks that the frame fits in the buffer. If it fits, it issues one read request per scanline, each carrying a byte address and a byte count. A frame that does not fit raises a sync error and fetches nothing.

The register unit supplies the panel width and height (each minus one), the palette mode, the subpanel word and the dual-buffer flag. It also supplies the two frame base addresses and the size of each buffer. The memory side is a single request/acknowledge pair: a request is held until it is acknowledged. When the palette block is acknowledged, the memory also returns the first palette entry on `pal_word`. In dual-buffer mode the block alternates between buffer 0 and buffer 1 from one frame to the next.

Top module: `lcd_fetch_seq`

## Requirements
- R1: After reset no request is pending, `cur_frame` is 0, `depth_bpp` is 0 and `cond_set`, `sync_err` and `frame_done` are all low.
- R2: A `start` pulse is ignored when `enable` is low or `pal_mode` is 1. No request is issued.
- R3: When `pal_mode` is 0 or 3, the first request of a frame has `req_pal`=1, the address of the current buffer (`base0` for index 0, `base1` for index 1) and a length of 512 bytes.
- R4: Bits 14:12 of the first palette entry give the depth code: 1 means 2 bpp, 2 means 4 bpp, 3 means 8 bpp, and 4 to 7 mean 16 bpp. After the check step `depth_bpp` shows this value. Code 0 gives `depth_bpp`=0 and skips the frame: no line request, no `cond_set`, no `sync_err` and no `frame_done`. All other bits of the entry are ignored.
- R5: Pixel data starts after a header. The header is 512 bytes for depth codes 3 to 7 and 32 bytes for codes 1 and 2. When `pal_mode` is 2, no palette request is made, the header is 0 bytes, and the depth code is the one captured by the most recent palette load (0 after reset).
- R6: The needed size is header + floor(width×height×bpp/8). If it is more than the buffer size + 2, then `sync_err` pulses for one cycle and no line request, `cond_set` or `frame_done` follows. A needed size exactly equal to size + 2 passes.
- R7: By default the lines run from 0 to height−1. If subpanel bit 31 is set, the field that starts at bit 16 (DIM_W bits wide) gives a line number L. With bit 29 also set, the first line is L. Otherwise L replaces the height as the end line. If the first line is not below the end line, no line is fetched.
- R8: A line request has `req_pal`=0 and a length equal to the stride, floor(width×bpp/8). Line n is addressed at frame base + header + stride×n.
- R9: A frame that passes the checks pulses `cond_set` for one cycle. Bit 0 marks buffer 0 and bit 1 marks buffer 1; the bit is that of the buffer being fetched.
- R10: After a frame that passes the checks, `cur_frame` toggles if `dual` is 1 and holds if `dual` is 0. A skipped or failing frame leaves it alone. While idle with `enable` low, it returns to 0.
- R11: `frame_done` pulses for exactly one cycle after the last line request is acknowledged. It also pulses when a passing frame has no lines.
- R12: A request holds its address, length and kind until `ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame tick |
| enable | input | 1 | Controller enabled |
| pal_mode | input | 2 | Palette mode (1: no fetch, 2: no palette) |
| hsize_m1 | input | DIM_W | Width minus one |
| vsize_m1 | input | DIM_W | Height minus one |
| subpanel | input | 32 | Subpanel word |
| dual | input | 1 | Alternate two buffers |
| base0 | input | AW | Buffer 0 byte address |
| base1 | input | AW | Buffer 1 byte address |
| size0 | input | AW | Buffer 0 size in bytes |
| size1 | input | AW | Buffer 1 size in bytes |
| req_valid | output | 1 | Read request pending |
| req_pal | output | 1 | Request is the palette block |
| req_addr | output | AW | Request byte address |
| req_len | output | AW | Request byte count |
| ack | input | 1 | Request accepted |
| pal_word | input | 16 | First palette entry, valid with ack of the palette request |
| depth_bpp | output | 5 | Bits per pixel decided for the last frame |
| cur_frame | output | 1 | Current buffer index |
| cond_set | output | 2 | Per-buffer frame-start pulse |
| sync_err | output | 1 | Size mismatch pulse |
| frame_done | output | 1 | Frame fetched pulse |

## Verification
The bench builds the block with AW=24 and DIM_W=4. This keeps every address short and every panel at most 16 lines, so each frame costs only a few dozen cycles. That makes room for a full sweep over all eight depth codes, three widths and three heights, and five subpanel settings (none, bit 29 without bit 31, moved start, moved end at 2 and at 0, start beyond the height). Each is run once with the buffer size exactly at the limit and once one byte short. Dual mode alternates through the sweep, so both buffer bases and both size inputs are exercised, and palette mode 2 is run both before and after any palette load.

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq #(
  parameter int AW        = 32,
  parameter int DIM_W     = 10,
  parameter int PAL_BYTES = 512,
  parameter int SHORT_HDR = 32,
  parameter int SLACK     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic [1:0]       pal_mode,
  input  logic [DIM_W-1:0] hsize_m1,
  input  logic [DIM_W-1:0] vsize_m1,
  input  logic [31:0]      subpanel,
  input  logic             dual,
  input  logic [AW-1:0]    base0,
  input  logic [AW-1:0]    base1,
  input  logic [AW-1:0]    size0,
  input  logic [AW-1:0]    size1,
  output logic             req_valid,
  output logic             req_pal,
  output logic [AW-1:0]    req_addr,
  output logic [AW-1:0]    req_len,
  input  logic             ack,
  input  logic [15:0]      pal_word,
  output logic [4:0]       depth_bpp,
  output logic             cur_frame,
  output logic [1:0]       cond_set,
  output logic             sync_err,
  output logic             frame_done
);
  localparam int LW = DIM_W + 1;
  localparam int SW = DIM_W + 6;
  localparam int PW = 2 * LW + 5;
  localparam int XW = ((PW > AW) ? PW : AW) + 2;

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_PAL  = 3'd1;
  localparam logic [2:0] S_CHK  = 3'd2;
  localparam logic [2:0] S_LINE = 3'd3;
  localparam logic [2:0] S_DONE = 3'd4;

  logic [2:0]    state;
  logic [2:0]    code_r;
  logic [LW-1:0] line_r, end_r;
  logic [AW-1:0] addr_r;
  logic [SW-1:0] stride_r;

  logic [4:0]    bpp;
  logic [AW-1:0] hdr, base_sel, size_sel, first_addr;
  logic [LW-1:0] w, h, sub_line, st_line, end_line, line_nx;
  logic [SW-1:0] stride;
  logic [PW-1:0] pix_bits;
  logic [XW-1:0] need, lim;

  wire unused_bits = ^{pal_word[15], pal_word[11:0], subpanel[30], subpanel[28:16+DIM_W], subpanel[15:0]};

  always_comb begin
    case (code_r)
      3'd0:    bpp = 5'd0;
      3'd1:    bpp = 5'd2;
      3'd2:    bpp = 5'd4;
      3'd3:    bpp = 5'd8;
      default: bpp = 5'd16;
    endcase
  end

  assign hdr = (pal_mode == 2'd2) ? '0 :
               (code_r >= 3'd3)   ? AW'(PAL_BYTES) : AW'(SHORT_HDR);

  assign base_sel = cur_frame ? base1 : base0;
  assign size_sel = cur_frame ? size1 : size0;

  assign w        = LW'(hsize_m1) + LW'(1);
  assign h        = LW'(vsize_m1) + LW'(1);
  assign sub_line = LW'(subpanel[16 +: DIM_W]);

  always_comb begin
    st_line  = '0;
    end_line = h;
    if (subpanel[31]) begin
      if (subpanel[29]) st_line  = sub_line;
      else              end_line = sub_line;
    end
  end

  assign stride     = SW'((SW'(w) * SW'(bpp)) >> 3);
  assign pix_bits   = PW'(w) * PW'(h) * PW'(bpp);
  assign need       = XW'(hdr) + XW'(pix_bits >> 3);
  assign lim        = XW'(size_sel) + XW'(SLACK);
  assign first_addr = base_sel + hdr + AW'(stride) * AW'(st_line);
  assign line_nx    = line_r + LW'(1);

  assign req_valid = (state == S_PAL) || (state == S_LINE);
  assign req_pal   = (state == S_PAL);
  assign req_addr  = req_pal ? base_sel : addr_r;
  assign req_len   = req_pal ? AW'(PAL_BYTES) : AW'(stride_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      code_r     <= '0;
      line_r     <= '0;
      end_r      <= '0;
      addr_r     <= '0;
      stride_r   <= '0;
      depth_bpp  <= '0;
      cur_frame  <= 1'b0;
      cond_set   <= '0;
      sync_err   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      cond_set   <= '0;
      sync_err   <= 1'b0;
      frame_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (!enable) cur_frame <= 1'b0;
          if (start && enable && pal_mode != 2'd1)
            state <= (pal_mode == 2'd2) ? S_CHK : S_PAL;
        end
        S_PAL: if (ack) begin
          code_r <= pal_word[14:12];
          state  <= S_CHK;
        end
        S_CHK: begin
          depth_bpp <= bpp;
          if (code_r == 3'd0) begin
            state <= S_IDLE;
          end else if (need > lim) begin
            sync_err <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cond_set <= cur_frame ? 2'b10 : 2'b01;
            if (dual) cur_frame <= ~cur_frame;
            addr_r   <= first_addr;
            stride_r <= stride;
            line_r   <= st_line;
            end_r    <= end_line;
            state    <= (st_line < end_line) ? S_LINE : S_DONE;
          end
        end
        S_LINE: if (ack) begin
          if (line_nx >= end_r) begin
            state <= S_DONE;
          end else begin
            line_r <= line_nx;
            addr_r <= addr_r + AW'(stride_r);
          end
        end
        S_DONE: begin
          frame_done <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_fetch_seq_chk.sv
module lcd_fetch_seq_chk #(
  parameter int AW        = 32,
  parameter int PAL_BYTES = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          enable,
  input logic [1:0]    pal_mode,
  input logic          dual,
  input logic          req_valid,
  input logic          req_pal,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] req_len,
  input logic          ack,
  input logic          cur_frame,
  input logic [1:0]    cond_set,
  input logic          sync_err,
  input logic          frame_done,
  input logic [2:0]    st
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ack) |=> (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_pal)));

  // R3
  pal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pal) |-> (req_len == AW'(PAL_BYTES)));

  // R2
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && start && (!enable || pal_mode == 2'd1)) |=> (st == 3'd0 && !req_valid));

  // R6
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (!req_valid && !frame_done && cond_set == 2'b00));

  // R9
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_set));

  // R9
  cond_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cond_set) |-> (cond_set == ($past(cur_frame) ? 2'b10 : 2'b01)));

  // R10
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cond_set) && !$past(dual)) |-> (cur_frame == $past(cur_frame)));

  // R10
  dual_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cond_set) && $past(dual)) |-> (cur_frame != $past(cur_frame)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind lcd_fetch_seq lcd_fetch_seq_chk #(.AW(AW), .PAL_BYTES(PAL_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .pal_mode(pal_mode),
  .dual(dual), .req_valid(req_valid), .req_pal(req_pal), .req_addr(req_addr),
  .req_len(req_len), .ack(ack), .cur_frame(cur_frame), .cond_set(cond_set),
  .sync_err(sync_err), .frame_done(frame_done), .st(state)
);

// File: tb/sim_lcd_fetch_seq.sv
`timescale 1ns/1ps
module sim_lcd_fetch_seq;
  localparam int AW = 24;
  localparam int DW = 4;
  localparam logic [AW-1:0] B0 = 24'h10_0000;
  localparam logic [AW-1:0] B1 = 24'h20_0400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, enable = 1'b0, dual = 1'b0, ack = 1'b0;
  logic [1:0] pal_mode = 2'd0;
  logic [DW-1:0] hsize_m1 = '0, vsize_m1 = '0;
  logic [31:0] subpanel = '0;
  logic [AW-1:0] base0 = B0, base1 = B1, size0 = '0, size1 = '0;
  logic [15:0] pal_word = '0;
  logic req_valid, req_pal, cur_frame, sync_err, frame_done;
  logic [AW-1:0] req_addr, req_len;
  logic [4:0] depth_bpp;
  logic [1:0] cond_set;

  lcd_fetch_seq #(.AW(AW), .DIM_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .pal_mode(pal_mode),
    .hsize_m1(hsize_m1), .vsize_m1(vsize_m1), .subpanel(subpanel), .dual(dual),
    .base0(base0), .base1(base1), .size0(size0), .size1(size1),
    .req_valid(req_valid), .req_pal(req_pal), .req_addr(req_addr), .req_len(req_len),
    .ack(ack), .pal_word(pal_word), .depth_bpp(depth_bpp), .cur_frame(cur_frame),
    .cond_set(cond_set), .sync_err(sync_err), .frame_done(frame_done)
  );

  int checks = 0, errors = 0;
  int mcode = 0;
  bit mf = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int bpp_of(input int c);
    case (c)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16;
    endcase
  endfunction

  // spm: 0 none, 1 start=spl, 2 end=spl
  task automatic run_frame(input int code, input int pm, input int w, input int h,
                           input int spm, input int spl, input bit dl, input int delta);
    int ec, bpp, hdr, need, sz, s, e, nl, stride;
    int npal, nline, ncond, nsync, ndone, quiet;
    bit fail;
    logic [1:0] condv;
    logic [AW-1:0] base;
    ec     = (pm == 2) ? mcode : code;
    bpp    = bpp_of(ec);
    hdr    = (pm == 2) ? 0 : ((ec >= 3) ? 512 : 32);
    need   = hdr + (w * h * bpp) / 8;
    sz     = need - 2 + delta;
    if (sz < 0) sz = 0;
    fail   = need > sz + 2;
    s = 0; e = h;
    if (spm == 1) s = spl;
    if (spm == 2) e = spl;
    nl     = (e > s) ? e - s : 0;
    stride = (w * bpp) / 8;
    base   = mf ? B1 : B0;
    hsize_m1 = DW'(w - 1);
    vsize_m1 = DW'(h - 1);
    case (spm)
      1:       subpanel = 32'hA000_0077 | (32'(spl) << 16);
      2:       subpanel = 32'h8000_0077 | (32'(spl) << 16);
      default: subpanel = 32'h2000_1234;
    endcase
    pal_word = {1'b1, 3'(code), 12'hABC};
    pal_mode = 2'(pm);
    dual     = dl;
    size0    = mf ? '0 : AW'(sz);
    size1    = mf ? AW'(sz) : '0;
    npal = 0; nline = 0; ncond = 0; nsync = 0; ndone = 0; quiet = 0; condv = '0;
    @(negedge clk); start = 1'b1;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      start = 1'b0;
      if (cond_set != 2'b00) begin ncond++; condv = cond_set; end
      if (sync_err) nsync++;
      if (frame_done) ndone++;
      if (ack) begin
        ack = 1'b0; quiet = 0;
      end else if (req_valid) begin
        ack = 1'b1; quiet = 0;
        if (req_pal) begin
          npal++;
          chk(req_addr == base, "R3", "palette address", req_addr, base);
          chk(req_len == 24'd512, "R3", "palette length", req_len, 512);
        end else begin
          chk(req_addr == base + AW'(hdr) + AW'(stride * (s + nline)), "R8", "line address",
              req_addr, base + AW'(hdr) + AW'(stride * (s + nline)));
          chk(req_len == AW'(stride), "R8", "line length", req_len, stride);
          nline++;
        end
      end else begin
        quiet++;
      end
      if (frame_done || sync_err || quiet >= 8) break;
    end
    chk(npal == ((pm == 2) ? 0 : 1), (pm == 2) ? "R5" : "R3", "palette requests", npal, (pm == 2) ? 0 : 1);
    if (ec == 0) begin
      chk(nline == 0 && ndone == 0 && ncond == 0 && nsync == 0, "R4", "skip events",
          nline + ndone + ncond + nsync, 0);
      chk(depth_bpp == 5'd0, "R4", "depth", depth_bpp, 0);
      chk(cur_frame == mf, "R10", "frame index after skip", cur_frame, mf);
    end else if (fail) begin
      chk(nsync == 1, "R6", "sync pulses", nsync, 1);
      chk(nline == 0 && ncond == 0 && ndone == 0, "R6", "events after error",
          nline + ncond + ndone, 0);
      chk(cur_frame == mf, "R10", "frame index after error", cur_frame, mf);
    end else begin
      chk(nsync == 0, "R6", "sync pulses", nsync, 0);
      chk(nline == nl, "R7", "line count", nline, nl);
      chk(ndone == 1, "R11", "done pulses", ndone, 1);
      chk(ncond == 1 && condv == (mf ? 2'b10 : 2'b01), "R9", "cond_set", condv, mf ? 2 : 1);
      chk(depth_bpp == 5'(bpp), "R4", "depth", depth_bpp, bpp);
      if (dl) mf = ~mf;
      chk(cur_frame == mf, "R10", "frame index", cur_frame, mf);
      @(negedge clk);
      chk(frame_done == 1'b0, "R11", "done width", frame_done, 0);
    end
    if (pm != 2) mcode = code;
  endtask

  task automatic ignored_start(input bit en, input int pm);
    int seen;
    seen = 0;
    enable = en; pal_mode = 2'(pm);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (req_valid || frame_done || sync_err || cond_set != 2'b00) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R2", "activity after ignored start", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1", "req_valid", req_valid, 0);
    chk(cur_frame == 1'b0, "R1", "cur_frame", cur_frame, 0);
    chk(depth_bpp == 5'd0, "R1", "depth_bpp", depth_bpp, 0);
    chk(cond_set == 2'b00 && !sync_err && !frame_done, "R1", "pulses",
        {cond_set, sync_err, frame_done}, 0);

    ignored_start(1'b0, 0);
    ignored_start(1'b1, 1);
    enable = 1'b1;

    // R5: no palette loaded yet, code 0 skips
    run_frame(5, 2, 3, 2, 0, 0, 1'b0, 0);

    for (int c = 0; c < 8; c++)
      for (int wi = 0; wi < 3; wi++)
        for (int hi = 0; hi < 3; hi++)
          for (int sp = 0; sp < 5; sp++)
            for (int d = 0; d < 2; d++) begin
              int spm, spl;
              case (sp)
                1: begin spm = 1; spl = 1; end
                2: begin spm = 2; spl = 2; end
                3: begin spm = 2; spl = 0; end
                4: begin spm = 1; spl = (1 << hi) + 1; end
                default: begin spm = 0; spl = 0; end
              endcase
              run_frame(c, (c == 6) ? 3 : 0, 1 + 2 * wi, 1 << hi, spm, spl, ((c + wi + hi) % 2) == 1, -d);
            end

    // R5: header 0 with the last loaded depth code
    run_frame(3, 0, 4, 2, 0, 0, 1'b0, 0);
    run_frame(6, 2, 4, 3, 0, 0, 1'b1, 0);
    run_frame(1, 0, 5, 4, 0, 0, 1'b0, 0);
    run_frame(7, 2, 5, 4, 1, 2, 1'b1, -1);
    run_frame(7, 2, 5, 4, 1, 2, 1'b1, 0);

    // R10: disabling returns the index to 0
    if (!mf) run_frame(4, 0, 2, 2, 0, 0, 1'b1, 0);
    chk(cur_frame == 1'b1, "R10", "index before disable", cur_frame, 1);
    enable = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(cur_frame == 1'b0, "R10", "index after disable", cur_frame, 0);
    mf = 1'b0;
    enable = 1'b1;
    run_frame(2, 0, 5, 2, 0, 0, 1'b0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule